// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block watches a host processor for signs of life. The host programs an 8-bit control byte that sets a timeout length and picks where an expiry goes. A slow 16 Hz enable drives the countdown. When the host touches the control byte, by a read or a write, the count starts over. If the host stays silent for the programmed time, the watchdog flag is raised. The expiry then goes to one of two places. It can assert a sticky interrupt that is shared with the frequency-test output. Or it can emit a reset pulse of fixed length, and in that case the control byte and the external frequency-test bit are cleared.

Each expiry lasts a coded number of ticks per multiplier unit. The multiplier field scales this value. A multiplier of zero turns the timer off. A separate strobe for reading the flags clears the flag and the interrupt.

Top module: `steer_wdog`

## Requirements
- R1: After a synchronous reset, the control byte reads 00h and all of `wdt_flag_o`, `irq_ft_o`, `rst_pulse_o` and `ft_clr_o` are low.
- R2: `acc_rdata_o` always shows the control byte. Bit 7 is the steering bit (0 = interrupt, 1 = reset pulse), bits 6..2 are the multiplier and bits 1..0 are the resolution code. A write with `acc_valid_i` and `acc_write_i` high stores `acc_wdata_i`.
- R3: The timeout is the multiplier times 1, 4, 16 or 64 ticks, for resolution codes 0, 1, 2 and 3. The flag rises on the tick that completes this many ticks after the last access. For example, 0Eh gives 48 ticks.
- R4: A multiplier of zero disables the timer, so no tick ever sets the flag.
- R5: Any access (`acc_valid_i` high, read or write) restarts the count from zero.
- R6: With the steering bit at 0, an expiry sets `wdt_flag_o` and drives `irq_ft_o` high. Both stay high until `flags_rd_i` is strobed or the control byte is accessed.
- R7: With the steering bit at 1, an expiry sets `wdt_flag_o` and raises `rst_pulse_o` for exactly PULSE_TICKS ticks. It also clears the control byte to 00h and pulses `ft_clr_o` for one cycle. It raises no interrupt.
- R8: `irq_ft_o` carries `ft_wave_i` only when `ft_en_i` is high, no interrupt is pending, and either the steering bit is 1 or the control byte is 00h. A pending interrupt forces the output high.
- R9: A tick that arrives in the same cycle as an access does not count, and it cannot cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | One-cycle 16 Hz time-base enable |
| acc_valid_i | input | 1 | Control byte access strobe |
| acc_write_i | input | 1 | Access is a write |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Current control byte |
| flags_rd_i | input | 1 | Flags register read strobe |
| ft_en_i | input | 1 | Frequency-test enable from the flag logic |
| ft_wave_i | input | 1 | Frequency-test square wave |
| wdt_flag_o | output | 1 | Watchdog flag |
| irq_ft_o | output | 1 | Interrupt / frequency-test output, active high |
| rst_pulse_o | output | 1 | Reset pulse, active high |
| ft_clr_o | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
The flag, the interrupt, the reset pulse and the clear request are all registered. Each one changes on the same clock edge that samples the completing tick, so it can be seen one cycle after that tick is driven. The bench drives every tick, access and strobe as a one-cycle pulse between falling edges. It checks results at the next falling edge, one edge after the stimulus. Read data and the frequency-test path are combinational, so they are sampled in the same cycle as their inputs.

// File: rtl/steer_wdog_pkg.sv
package steer_wdog_pkg;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int CFG_W  = 1 + MULT_W + RES_W;
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W  = MULT_W + MAX_SHIFT;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;

    function automatic logic [CNT_W-1:0] timeout_ticks(wd_cfg_t c);
        logic [CNT_W-1:0] m;
        m = CNT_W'(c.mult);
        return m << (2 * int'(c.res));
    endfunction
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import steer_wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  wd_cfg_t wr_val,
    input  logic    self_clear,
    output wd_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || self_clear)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wr_val;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  logic          enable,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = tick && enable && !restart && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || restart || !enable)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= expire ? '0 : cnt_q + CW'(1);
    end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic tick,
    output logic active
);
    localparam int PW = $clog2(LEN_TICKS + 1);
    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (fire)
            left_q <= PW'(LEN_TICKS);
        else if (tick && left_q != '0)
            left_q <= left_q - PW'(1);
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/steer_wdog.sv
module steer_wdog
    import steer_wdog_pkg::*;
#(
    parameter int PULSE_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16_i,
    input  logic             acc_valid_i,
    input  logic             acc_write_i,
    input  logic [CFG_W-1:0] acc_wdata_i,
    output logic [CFG_W-1:0] acc_rdata_o,
    input  logic             flags_rd_i,
    input  logic             ft_en_i,
    input  logic             ft_wave_i,
    output logic             wdt_flag_o,
    output logic             irq_ft_o,
    output logic             rst_pulse_o,
    output logic             ft_clr_o
);
    wd_cfg_t          cfg;
    logic             expire;
    logic             reset_fire;
    logic             wf_q;
    logic             irq_q;
    logic             ftclr_q;
    logic [CNT_W-1:0] limit;

    assign limit      = timeout_ticks(cfg);
    assign reset_fire = expire && cfg.steer;

    wdog_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (acc_valid_i && acc_write_i),
        .wr_val     (wd_cfg_t'(acc_wdata_i)),
        .self_clear (reset_fire),
        .cfg_q      (cfg)
    );

    wdog_counter #(.CW(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16_i),
        .restart (acc_valid_i),
        .enable  (cfg.mult != '0),
        .limit   (limit),
        .expire  (expire)
    );

    wdog_pulse #(.LEN_TICKS(PULSE_TICKS)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (reset_fire),
        .tick   (tick16_i),
        .active (rst_pulse_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wf_q    <= 1'b0;
            irq_q   <= 1'b0;
            ftclr_q <= 1'b0;
        end else begin
            ftclr_q <= reset_fire;
            if (expire) begin
                wf_q  <= 1'b1;
                irq_q <= irq_q || !cfg.steer;
            end else if (flags_rd_i || acc_valid_i) begin
                wf_q  <= 1'b0;
                irq_q <= 1'b0;
            end
        end
    end

    assign acc_rdata_o = cfg;
    assign wdt_flag_o  = wf_q;
    assign ft_clr_o    = ftclr_q;
    assign irq_ft_o    = irq_q ||
                         (ft_en_i && ft_wave_i && (cfg.steer || cfg == '0));
endmodule

// File: rtl/steer_wdog_chk.sv
module steer_wdog_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid_i,
    input logic       flags_rd_i,
    input logic [7:0] acc_rdata_o,
    input logic       wdt_flag_o,
    input logic       irq_ft_o,
    input logic       rst_pulse_o,
    input logic       ft_clr_o,
    input logic       irq_q
);
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !flags_rd_i && !acc_valid_i) |=> irq_q);

    a_r8_irq_wins: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> irq_ft_o);

    a_r7_cfg_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_pulse_o) |-> (acc_rdata_o == 8'h00 && ft_clr_o));

    a_r7_clr_single: assert property (@(posedge clk) disable iff (rst)
        ft_clr_o |=> !ft_clr_o);

    a_r4_disabled: assert property (@(posedge clk) disable iff (rst)
        (acc_rdata_o[6:2] == 5'd0) |=> !$rose(wdt_flag_o));

    a_r5_access_clears: assert property (@(posedge clk) disable iff (rst)
        acc_valid_i |=> !wdt_flag_o);
endmodule

bind steer_wdog steer_wdog_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid_i (acc_valid_i),
    .flags_rd_i  (flags_rd_i),
    .acc_rdata_o (acc_rdata_o),
    .wdt_flag_o  (wdt_flag_o),
    .irq_ft_o    (irq_ft_o),
    .rst_pulse_o (rst_pulse_o),
    .ft_clr_o    (ft_clr_o),
    .irq_q       (irq_q)
);

// File: tb/steer_wdog_test.sv
module steer_wdog_test;
    localparam int PULSE = 2;
    localparam int NV = 5;
    localparam logic [7:0] V_CFG   [0:NV-1] = '{8'h04, 8'h05, 8'h0E, 8'h0B, 8'h7C};
    localparam int         V_TICKS [0:NV-1] = '{1, 4, 48, 128, 31};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, acc_v = 1'b0, acc_w = 1'b0, frd = 1'b0;
    logic ft_en = 1'b0, ft_wave = 1'b0;
    logic [7:0] wdata = 8'h00, rdata;
    logic flag, irq_ft, rpulse, ftclr;
    int checks = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    steer_wdog #(.PULSE_TICKS(PULSE)) uut (
        .clk(clk), .rst(rst), .tick16_i(tick), .acc_valid_i(acc_v),
        .acc_write_i(acc_w), .acc_wdata_i(wdata), .acc_rdata_o(rdata),
        .flags_rd_i(frd), .ft_en_i(ft_en), .ft_wave_i(ft_wave),
        .wdt_flag_o(flag), .irq_ft_o(irq_ft), .rst_pulse_o(rpulse),
        .ft_clr_o(ftclr)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic wr(logic [7:0] v, logic with_tick);
        @(negedge clk) begin acc_v = 1'b1; acc_w = 1'b1; wdata = v; tick = with_tick; end
        @(negedge clk) begin acc_v = 1'b0; acc_w = 1'b0; tick = 1'b0; end
    endtask

    task automatic rd();
        @(negedge clk) acc_v = 1'b1;
        @(negedge clk) acc_v = 1'b0;
    endtask

    task automatic flags_read();
        @(negedge clk) frd = 1'b1;
        @(negedge clk) frd = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg", rdata, 8'h00);
        chk("R1 outs", {4'h0, flag, irq_ft, rpulse, ftclr}, 8'h00);

        // R2 readback of fields
        wr(8'h2A, 1'b0);
        chk("R2 readback", rdata, 8'h2A);
        wr(8'h00, 1'b0);

        // R3/R6 vector table, steering to interrupt
        for (int v = 0; v < NV; v++) begin
            wr(V_CFG[v], 1'b0);
            ticks(V_TICKS[v] - 1);
            chk($sformatf("R3 early cfg=%h", V_CFG[v]), {7'h0, flag}, 8'h00);
            ticks(1);
            chk($sformatf("R3 due cfg=%h", V_CFG[v]), {7'h0, flag}, 8'h01);
            chk("R6 irq up", {7'h0, irq_ft}, 8'h01);
            flags_read();
            chk("R6 flags read clears", {6'h0, flag, irq_ft}, 8'h00);
        end

        // R4 multiplier zero disables
        wr(8'h03, 1'b0);
        ticks(200);
        chk("R4 disabled", {7'h0, flag}, 8'h00);

        // R5 restart on read
        wr(8'h14, 1'b0);
        ticks(4);
        rd();
        ticks(4);
        chk("R5 restarted", {7'h0, flag}, 8'h00);
        ticks(1);
        chk("R5 due", {7'h0, flag}, 8'h01);

        // R6 hold until register access
        ticks(10);
        chk("R6 held", {6'h0, flag, irq_ft}, 8'h03);
        rd();
        chk("R6 access clears", {6'h0, flag, irq_ft}, 8'h00);

        // R9 tick concurrent with access is ignored
        wr(8'h04, 1'b1);
        chk("R9 no expiry", {7'h0, flag}, 8'h00);
        ticks(1);
        chk("R9 later tick", {7'h0, flag}, 8'h01);
        flags_read();

        // R8 frequency test gating
        ft_en = 1'b1; ft_wave = 1'b1;
        wr(8'h00, 1'b0);
        chk("R8 ft passes when cfg 00", {7'h0, irq_ft}, 8'h01);
        ft_wave = 1'b0;
        @(negedge clk);
        chk("R8 ft low phase", {7'h0, irq_ft}, 8'h00);
        ft_wave = 1'b1;
        wr(8'h10, 1'b0);
        chk("R8 ft denied steer0", {7'h0, irq_ft}, 8'h00);
        ticks(4);
        ft_wave = 1'b0;
        @(negedge clk);
        chk("R8 irq overrides", {7'h0, irq_ft}, 8'h01);
        flags_read();

        // R7 reset pulse path
        ft_wave = 1'b1;
        wr(8'h84, 1'b0);
        chk("R8 ft passes steer1", {7'h0, irq_ft}, 8'h01);
        ft_wave = 1'b0;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk("R7 pulse/clr/flag", {5'h0, flag, rpulse, ftclr}, 8'h07);
        chk("R7 cfg cleared", rdata, 8'h00);
        chk("R7 no irq", {7'h0, irq_ft}, 8'h00);
        @(negedge clk);
        chk("R7 clr one cycle", {7'h0, ftclr}, 8'h00);
        ticks(PULSE - 1);
        chk("R7 pulse still on", {7'h0, rpulse}, 8'h01);
        ticks(1);
        chk("R7 pulse ended", {7'h0, rpulse}, 8'h00);

        // R1 reset mid-run
        wr(8'h7F, 1'b0);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 reset again", rdata, 8'h00);

        finish_run();
    end
endmodule